// File: doc/BRIEF.md
# Polarity-Configurable Digital I/O Port

A sixteen-line general purpose I/O port behind a small byte-wide register bus. Every line has three configuration bits: a direction bit that enables its output driver, a value bit that says whether the line is asserted, and a polarity bit that flips the level the pad sees. A pair of read-only status bytes returns the raw pad levels after a two-flop synchroniser.

Software writes configuration with a single-cycle write strobe and reads any register combinationally through the same address. The output-value registers read back what was written, not the pad. Comparing them with the status registers therefore shows when a line set as output is being held the other way from outside. A strap input decides whether a platform reset clears the configuration or leaves it alone. Power-on reset always clears it.

Top module: `gpio_pol_port`

## Requirements
- R1: After power-on reset (rst_ni low) every configuration bit is 0. All reads of offsets 0x0-0x3 and 0x6-0x7 return 0x00, pin_oe_o is 0 and pin_o is 0. This holds whatever the strap level is.
- R2: The offsets are: polarity 0x0/0x1, output value 0x2/0x3, input status 0x4/0x5 and direction 0x6/0x7. The even offset holds lines 1-8 in bits 0-7, and the odd offset holds lines 9-16. A write takes effect at the clock edge that samples wr_en_i, and a read returns the stored byte.
- R3: pin_o[n] equals value bit n XOR polarity bit n. A value of 1 drives high when not inverted and low when inverted.
- R4: pin_oe_o[n] is 1 exactly when direction bit n is 1 (1 = output, 0 = input).
- R5: Reading 0x2/0x3 returns the written value even when the pad level differs from the driven level.
- R6: Reading 0x4/0x5 returns the raw pad level, with no polarity inversion and whatever the direction is. The level shows two clock edges after it is presented on pin_i.
- R7: Writes to 0x4/0x5 and to unmapped offsets 0x8-0xF change nothing. Reads of unmapped offsets return 0x00.
- R8: With keep_cfg_i = 0, a clock edge that sees plat_rst_ni low clears polarity, value and direction. A write in the same cycle is dropped.
- R9: With keep_cfg_i = 1, plat_rst_ni has no effect on polarity, value or direction, and writes during it still land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| plat_rst_ni | input | 1 | Platform reset, active low, sampled on the clock |
| keep_cfg_i | input | 1 | Strap: 1 keeps configuration through platform reset |
| addr_i | input | 4 | Register offset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| pin_i | input | 16 | Pad input levels, line 1 in bit 0 |
| pin_o | output | 16 | Pad output levels after polarity |
| pin_oe_o | output | 16 | Pad output enables |

## Verification
The hardest case to reach is a real drive conflict, where a line is an output and the pad reads the opposite level. The bench forces pin_i to the complement of pin_o, waits past the synchroniser, then reads both the value and status registers and expects them to disagree. Retention needs the strap held at 1 while platform reset pulses and a write lands in the middle of the pulse. The same pulse is then repeated with the strap at 0. A behavioural model runs beside the design and is compared on every clock.

// File: rtl/gpio_pol_pkg.sv
package gpio_pol_pkg;
  typedef enum logic [1:0] {
    K_POL = 2'd0,
    K_OUT = 2'd1,
    K_IN  = 2'd2,
    K_DIR = 2'd3
  } kind_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pol_pkg::*;
#(
  parameter int LINES = 16,
  parameter int BW    = 8,
  localparam int NBYTE = LINES / BW,
  localparam int SW    = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             we_i,
  input  kind_e            kind_i,
  input  logic [SW-1:0]    byte_i,
  input  logic [BW-1:0]    wdata_i,
  output logic [LINES-1:0] pol_o,
  output logic [LINES-1:0] out_o,
  output logic [LINES-1:0] dir_o
);
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    logic [BW-1:0] pol_q, out_q, dir_q;
    logic          hit;
    assign hit = we_i && (byte_i == SW'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pol_q <= '0;
        out_q <= '0;
        dir_q <= '0;
      end else if (clr_i) begin
        // strap-qualified platform reset beats a concurrent write
        pol_q <= '0;
        out_q <= '0;
        dir_q <= '0;
      end else if (hit) begin
        case (kind_i)
          K_POL:   pol_q <= wdata_i;
          K_OUT:   out_q <= wdata_i;
          K_DIR:   dir_q <= wdata_i;
          default: ;
        endcase
      end
    end

    assign pol_o[b*BW +: BW] = pol_q;
    assign out_o[b*BW +: BW] = out_q;
    assign dir_o[b*BW +: BW] = dir_q;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
  parameter int LINES = 16
) (
  input  logic [LINES-1:0] pol_i,
  input  logic [LINES-1:0] out_i,
  input  logic [LINES-1:0] dir_i,
  output logic [LINES-1:0] pin_o,
  output logic [LINES-1:0] pin_oe_o
);
  for (genvar n = 0; n < LINES; n++) begin : g_line
    assign pin_o[n]    = out_i[n] ^ pol_i[n];
    assign pin_oe_o[n] = dir_i[n];
  end
endmodule

// File: rtl/gpio_pol_port.sv
module gpio_pol_port
  import gpio_pol_pkg::*;
#(
  parameter int LINES = 16,
  parameter int BW    = 8,
  parameter int AW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             plat_rst_ni,
  input  logic             keep_cfg_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_i,
  input  logic [BW-1:0]    wdata_i,
  output logic [BW-1:0]    rdata_o,
  input  logic [LINES-1:0] pin_i,
  output logic [LINES-1:0] pin_o,
  output logic [LINES-1:0] pin_oe_o
);
  localparam int NBYTE = LINES / BW;
  localparam int SW    = (NBYTE > 1) ? $clog2(NBYTE) : 1;
  localparam int MAPW  = SW + 2;

  logic [LINES-1:0] pol_w, out_w, dir_w, sync_w;
  logic [SW-1:0]    byte_sel;
  kind_e            kind;
  logic             mapped, cfg_we, cfg_clr;

  assign byte_sel = addr_i[SW-1:0];
  assign kind     = kind_e'(addr_i[SW+1:SW]);
  assign mapped   = (addr_i >> MAPW) == '0;
  assign cfg_we   = wr_en_i && mapped && (kind != K_IN);
  assign cfg_clr  = !plat_rst_ni && !keep_cfg_i;

  gpio_cfg_regs #(.LINES(LINES), .BW(BW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cfg_clr),
    .we_i    (cfg_we),
    .kind_i  (kind),
    .byte_i  (byte_sel),
    .wdata_i (wdata_i),
    .pol_o   (pol_w),
    .out_o   (out_w),
    .dir_o   (dir_w)
  );

  gpio_in_sync #(.W(LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (sync_w)
  );

  gpio_pin_drive #(.LINES(LINES)) u_drv (
    .pol_i    (pol_w),
    .out_i    (out_w),
    .dir_i    (dir_w),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
  );

  always_comb begin
    rdata_o = '0;
    if (mapped) begin
      case (kind)
        K_POL: rdata_o = pol_w[byte_sel*BW +: BW];
        K_OUT: rdata_o = out_w[byte_sel*BW +: BW];
        K_IN:  rdata_o = sync_w[byte_sel*BW +: BW];
        K_DIR: rdata_o = dir_w[byte_sel*BW +: BW];
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pol_port_chk.sv
module gpio_pol_port_chk #(
  parameter int LINES = 16,
  parameter int BW    = 8,
  parameter int AW    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             plat_rst_ni,
  input logic             keep_cfg_i,
  input logic [AW-1:0]    addr_i,
  input logic             wr_en_i,
  input logic [BW-1:0]    wdata_i,
  input logic [BW-1:0]    rdata_o,
  input logic [LINES-1:0] pin_i,
  input logic [LINES-1:0] pin_o,
  input logic [LINES-1:0] pin_oe_o,
  input logic [LINES-1:0] cfg_pol,
  input logic [LINES-1:0] cfg_out,
  input logic [LINES-1:0] cfg_dir
);
  logic [1:0] age_q;
  logic       clr;
  assign clr = !plat_rst_ni && !keep_cfg_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R3: a value write shows on the pad with the stored polarity applied
  a_r3_value_to_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'h2 && !clr) |=> (pin_o[BW-1:0] == ($past(wdata_i) ^ cfg_pol[BW-1:0])));

  // R4: a direction write drives the enables one edge later
  a_r4_dir_to_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'h7 && !clr) |=> (pin_oe_o[LINES-1:BW] == $past(wdata_i)));

  // R6: the status byte trails the pad by two edges
  a_r6_sync_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && addr_i == 4'h4) |-> (rdata_o == $past(pin_i[BW-1:0], 2)));

  // R7: status or unmapped writes leave the configuration alone
  a_r7_dead_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i[3] || addr_i[2:1] == 2'b10) && !clr)
      |=> ($stable(cfg_pol) && $stable(cfg_out) && $stable(cfg_dir)));

  // R8: strap low lets platform reset clear the configuration
  a_r8_plat_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (pin_oe_o == '0 && cfg_out == '0 && cfg_pol == '0));

  // R9: strap high keeps the configuration when nothing is written
  a_r9_plat_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!plat_rst_ni && keep_cfg_i && !wr_en_i)
      |=> ($stable(cfg_pol) && $stable(cfg_out) && $stable(cfg_dir)));

  // R7: unmapped reads return zero
  always_comb begin
    if (rst_ni && addr_i[3]) a_r7_unmapped_zero: assert (rdata_o == '0);
  end
endmodule

bind gpio_pol_port gpio_pol_port_chk #(.LINES(LINES), .BW(BW), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .plat_rst_ni (plat_rst_ni),
  .keep_cfg_i  (keep_cfg_i),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .pin_i       (pin_i),
  .pin_o       (pin_o),
  .pin_oe_o    (pin_oe_o),
  .cfg_pol     (pol_w),
  .cfg_out     (out_w),
  .cfg_dir     (dir_w)
);

// File: tb/sim_gpio_pol_port.sv
`timescale 1ns/1ps
module sim_gpio_pol_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        plat_n = 1'b1;
  logic        keep = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wd = '0;
  logic [7:0]  rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  gpio_pol_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .plat_rst_ni(plat_n), .keep_cfg_i(keep),
    .addr_i(addr), .wr_en_i(we), .wdata_i(wd), .rdata_o(rdata),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe)
  );

  // behavioural reference
  logic [15:0] m_pol, m_out, m_dir, m_s1, m_s2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pol <= 0; m_out <= 0; m_dir <= 0; m_s1 <= 0; m_s2 <= 0;
    end else begin
      m_s1 <= pin_in;
      m_s2 <= m_s1;
      if (!plat_n && !keep) begin
        m_pol <= 0; m_out <= 0; m_dir <= 0;
      end else if (we) begin
        case (addr)
          4'h0: m_pol[7:0]  <= wd;
          4'h1: m_pol[15:8] <= wd;
          4'h2: m_out[7:0]  <= wd;
          4'h3: m_out[15:8] <= wd;
          4'h6: m_dir[7:0]  <= wd;
          4'h7: m_dir[15:8] <= wd;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] m_read(input logic [3:0] a);
    case (a)
      4'h0: return m_pol[7:0];
      4'h1: return m_pol[15:8];
      4'h2: return m_out[7:0];
      4'h3: return m_out[15:8];
      4'h4: return m_s2[7:0];
      4'h5: return m_s2[15:8];
      4'h6: return m_dir[7:0];
      4'h7: return m_dir[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    cyc++;
    #1;
    if (rst_n) begin
      chk("R3 pad level", pin_out, m_out ^ m_pol);
      chk("R4 enable", pin_oe, m_dir);
      chk("R2 read mux", {8'h00, rdata}, {8'h00, m_read(addr)});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wd = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    we = 1'b0; addr = a;
    #1;
    chk(tag, {8'h00, rdata}, {8'h00, exp});
  endtask

  task automatic cfg_load();
    wr(4'h0, 8'h0F); wr(4'h1, 8'hA0);
    wr(4'h2, 8'h55); wr(4'h3, 8'h3C);
    wr(4'h6, 8'hFF); wr(4'h7, 8'h0F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    for (int a = 0; a < 8; a++) if (a != 4 && a != 5) rd(4'(a), 8'h00, "R1 reset value");
    chk("R1 oe reset", pin_oe, 16'h0000);
    chk("R1 pad reset", pin_out, 16'h0000);

    // R2
    cfg_load();
    rd(4'h0, 8'h0F, "R2 pol low");
    rd(4'h1, 8'hA0, "R2 pol high");
    rd(4'h3, 8'h3C, "R2 out high");
    rd(4'h6, 8'hFF, "R2 dir low");
    rd(4'h7, 8'h0F, "R2 dir high");
    // R3 / R4
    chk("R3 pad after load", pin_out, 16'h9C5A);
    chk("R4 oe after load", pin_oe, 16'h0FFF);

    // R5 / R6 conflict: pads forced opposite of drive
    @(negedge clk); pin_in = ~16'h9C5A;
    repeat (3) @(negedge clk);
    rd(4'h2, 8'h55, "R5 value readback under conflict");
    rd(4'h4, 8'hA5, "R6 raw pad low");
    rd(4'h5, 8'h63, "R6 raw pad high, input lines");

    // R6 latency
    @(negedge clk); addr = 4'h4; pin_in = 16'h1234;
    @(posedge clk); #1; chk("R6 one edge old", {8'h00, rdata}, 16'h00A5);
    @(posedge clk); #1; chk("R6 two edges new", {8'h00, rdata}, 16'h0034);

    // R7
    wr(4'h4, 8'hFF); wr(4'h5, 8'h00); wr(4'h9, 8'hFF); wr(4'hE, 8'h77);
    rd(4'h4, 8'h34, "R7 status write ignored");
    rd(4'h5, 8'h12, "R7 status high write ignored");
    rd(4'h9, 8'h00, "R7 unmapped read");
    rd(4'hE, 8'h00, "R7 unmapped read high");
    rd(4'h0, 8'h0F, "R7 pol untouched");
    rd(4'h2, 8'h55, "R7 out untouched");
    chk("R7 oe untouched", pin_oe, 16'h0FFF);

    // R9 strap high: retention, and a write during platform reset lands
    @(negedge clk); keep = 1'b1; plat_n = 1'b0;
    repeat (3) @(negedge clk);
    addr = 4'h3; wd = 8'hC3; we = 1'b1;
    @(negedge clk); we = 1'b0; plat_n = 1'b1;
    rd(4'h1, 8'hA0, "R9 pol kept");
    rd(4'h2, 8'h55, "R9 out kept");
    rd(4'h3, 8'hC3, "R9 write during plat reset");
    chk("R9 oe kept", pin_oe, 16'h0FFF);

    // R8 strap low: clear, write in same cycle dropped
    @(negedge clk); keep = 1'b0; plat_n = 1'b0;
    addr = 4'h6; wd = 8'hAA; we = 1'b1;
    @(negedge clk); we = 1'b0; plat_n = 1'b1;
    rd(4'h6, 8'h00, "R8 dir cleared, write dropped");
    rd(4'h1, 8'h00, "R8 pol cleared");
    rd(4'h3, 8'h00, "R8 out cleared");
    chk("R8 oe cleared", pin_oe, 16'h0000);
    chk("R8 pad cleared", pin_out, 16'h0000);

    // R1 power-on reset clears even with strap high
    cfg_load();
    @(negedge clk); keep = 1'b1; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(4'h0, 8'h00, "R1 power-on clears with strap high");
    rd(4'h7, 8'h00, "R1 dir cleared");
    chk("R1 oe after power-on", pin_oe, 16'h0000);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule